// File: doc/BRIEF.md
# Byte-Wide Serializer/Deserializer with Loopback Paths

The block models the digital datapath of a byte-wide serial transceiver inside one bit-clock domain. On the transmit side it takes an 8-bit byte once every eight clocks and shifts it out one bit per clock, most significant bit first. On the receive side it gathers serial bits, qualified by a per-bit valid strobe that stands in for the recovered clock, into 8-bit bytes. Byte boundaries come from a modulo-8 count of accepted bits that starts at reset. No framing search is done.

Three loopback controls reroute the streams. The equipment loopback sends the transmit serial stream into the receive byte assembler, and the transmit output keeps running. The serial-I/O loopback replaces the external receive input with the transmit stream, ahead of everything that uses the recovered timing. The facility loopback drives the serial output with the received stream, after an 8:1 regroup timed by the recovered bit strobe. Byte alignment holds from reset, so a mode is chosen while reset is low and held afterwards.

Top module: `byte_serdes_lb`

## Requirements
- R1: `ser_out` with no facility loopback carries the byte captured at a `tx_load` cycle, bit 7 in the next cycle, then bits 6 down to 0 in the cycles that follow. `ser_out` is 0 before the first byte.
- R2: `tx_load` is high for exactly one cycle in every eight, starting in the first cycle after reset release. `tx_byte` is captured at the clock edge that ends that cycle.
- R3: The receiver groups accepted bits into eights counted from reset. The first bit of each group lands in `rx_byte[7]`. The byte appears with a one-cycle `rx_byte_vld` in the cycle after the eighth bit is sampled, and `rx_byte` holds its value at all other times.
- R4: A cycle with `rx_bit_vld` low is ignored. Its `rx_ser_in` value is neither stored nor counted.
- R5: With all loopback controls low, `ser_out` carries only transmit bytes and `rx_byte` carries only bytes built from `rx_ser_in`.
- R6: With `lb_equip` high, `rx_byte` delivers the transmit bytes in order, one every eight cycles, timed by the internal clock. External receive input is ignored and `ser_out` still carries the transmit bytes.
- R7: With `lb_hsio` high, the transmit serial stream replaces `rx_ser_in`/`rx_bit_vld` for both the parallel receive output and the facility path.
- R8: With `lb_facility` high, after the k-th accepted receive bit (k counted from 1, k >= 9), `ser_out` equals receive bit k-8. It is 0 until nine bits have been accepted, and it changes only in the cycle after an accepted bit.
- R9: With `lb_equip` and `lb_facility` both high, `rx_byte` follows the equipment loopback and `ser_out` follows the facility loopback.
- R10: During reset, `rx_byte` is 0, `rx_byte_vld` is 0, `ser_out` is 0 and `tx_load` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock |
| rst_n | input | 1 | Synchronous reset, active low |
| lb_equip | input | 1 | Equipment loopback: transmit stream into the receive byte output |
| lb_hsio | input | 1 | Serial-I/O loopback: transmit stream replaces the external receive input |
| lb_facility | input | 1 | Facility loopback: receive stream drives the serial output |
| tx_byte | input | 8 | Transmit byte, captured when `tx_load` is high |
| tx_load | output | 1 | One-cycle strobe: the serializer takes `tx_byte` at the next edge |
| ser_out | output | 1 | Serial output |
| rx_ser_in | input | 1 | External serial receive data |
| rx_bit_vld | input | 1 | Recovered-clock strobe qualifying `rx_ser_in` |
| rx_byte | output | 8 | Received byte |
| rx_byte_vld | output | 1 | One-cycle strobe marking a new `rx_byte` |

## Verification
The hardest case to reach is the facility path when the recovered-bit strobe is irregular. There the serial output has to track the receive stream eight accepted bits behind, hold still through the gaps, and stay aligned to byte groups counted from reset. The stimulus reaches this with pseudo-random strobe patterns of about one bit in two and one bit in three, and with random data in the gaps that must not show up. The same sparse patterns run with the equipment loopback on, which shows that the external input is ignored while the serial output still comes from the facility path.

// File: rtl/serdes_lb_pkg.sv
// Shared definitions for the byte serdes with loopback paths.
// Assumes one bit-rate clock; byte clocks are modelled as strobes.
package serdes_lb_pkg;
    localparam int unsigned BYTE_W = 8;
    localparam int unsigned CNT_W  = $clog2(BYTE_W);
    typedef logic [BYTE_W-1:0] byte_t;
endpackage

// File: rtl/sdl_tx_serializer.sv
// Parallel-to-serial stage: captures one word every W clocks and shifts it
// out MSB first, one bit per clock. Assumes a free-running W-cycle phase
// counter that starts at reset. primed_o marks that real data is on bit_o.
module sdl_tx_serializer #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] par_i,
    output logic         load_o,
    output logic         bit_o,
    output logic         primed_o
);
    localparam int unsigned CW = $clog2(W);

    logic [CW-1:0] phase_q;
    logic [W-1:0]  shift_q;

    assign load_o = (phase_q == '0);
    assign bit_o  = shift_q[W-1];

    // Free-running word phase counter.
    always_ff @(posedge clk) begin
        if (!rst_n)                       phase_q <= '0;
        else if (phase_q == CW'(W - 1))   phase_q <= '0;
        else                              phase_q <= phase_q + 1'b1;
    end

    // Load a new word at phase 0, otherwise shift towards the MSB.
    always_ff @(posedge clk) begin
        if (!rst_n)      shift_q <= '0;
        else if (load_o) shift_q <= par_i;
        else             shift_q <= {shift_q[W-2:0], 1'b0};
    end

    // Note that the first word has reached the output.
    always_ff @(posedge clk) begin
        if (!rst_n)      primed_o <= 1'b0;
        else if (load_o) primed_o <= 1'b1;
    end

    // R2
    tx_ld_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_o |=> !load_o);
endmodule

// File: rtl/sdl_rx_deserializer.sv
// Serial-to-parallel stage: shifts in a bit on each enabled clock and
// presents a word after every W accepted bits. The first bit of a group
// ends up in the MSB. Group boundaries count from reset, with no framing.
module sdl_rx_deserializer #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         bit_i,
    input  logic         en_i,
    output logic [W-1:0] word_o,
    output logic         vld_o
);
    localparam int unsigned CW = $clog2(W);

    logic [CW-1:0] count_q;
    logic [W-1:0]  shift_q;
    logic          last_bit;

    assign last_bit = en_i && (count_q == CW'(W - 1));

    // Count accepted bits modulo W.
    always_ff @(posedge clk) begin
        if (!rst_n)        count_q <= '0;
        else if (last_bit) count_q <= '0;
        else if (en_i)     count_q <= count_q + 1'b1;
    end

    // Shift accepted bits in at the LSB.
    always_ff @(posedge clk) begin
        if (!rst_n)    shift_q <= '0;
        else if (en_i) shift_q <= {shift_q[W-2:0], bit_i};
    end

    // Present the finished word with a one-cycle strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_o <= '0;
            vld_o  <= 1'b0;
        end else begin
            vld_o <= last_bit;
            if (last_bit) word_o <= {shift_q[W-2:0], bit_i};
        end
    end

    // R3
    rx_vld_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vld_o |=> !vld_o);
    // R3
    rx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !vld_o |-> $stable(word_o));
endmodule

// File: rtl/sdl_fac_reserializer.sv
// Facility regroup stage: serializes the words of a receive deserializer
// again, one bit per enabled clock. Assumes its word phase matches the
// deserializer it follows, since both count the same enables from reset.
module sdl_fac_reserializer #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] word_i,
    input  logic         en_i,
    output logic         bit_o
);
    localparam int unsigned CW = $clog2(W);

    logic [CW-1:0] count_q;
    logic [W-1:0]  shift_q;

    assign bit_o = shift_q[W-1];

    // Word phase over enabled clocks.
    always_ff @(posedge clk) begin
        if (!rst_n)                                count_q <= '0;
        else if (en_i && count_q == CW'(W - 1))    count_q <= '0;
        else if (en_i)                             count_q <= count_q + 1'b1;
    end

    // Load the held word at phase 0, otherwise shift on each enable.
    always_ff @(posedge clk) begin
        if (!rst_n)                        shift_q <= '0;
        else if (en_i && count_q == '0)    shift_q <= word_i;
        else if (en_i)                     shift_q <= {shift_q[W-2:0], 1'b0};
    end

    // R8
    fac_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(en_i) |-> $stable(bit_o));
endmodule

// File: rtl/byte_serdes_lb.sv
// Top of the byte serdes model. Routes the transmit stream, the external
// receive stream and the facility regroup output according to three
// loopback controls. Assumes the controls are set while reset is low and
// held afterwards, because byte phase counts from reset.
module byte_serdes_lb
    import serdes_lb_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        lb_equip,
    input  logic        lb_hsio,
    input  logic        lb_facility,
    input  logic [7:0]  tx_byte,
    output logic        tx_load,
    output logic        ser_out,
    input  logic        rx_ser_in,
    input  logic        rx_bit_vld,
    output logic [7:0]  rx_byte,
    output logic        rx_byte_vld
);
    logic  tx_bit, tx_primed;
    logic  rec_bit, rec_en;
    logic  fac_bit;
    byte_t rec_word, eq_word;
    logic  rec_vld, eq_vld;

    sdl_tx_serializer #(.W(BYTE_W)) u_tx (
        .clk(clk), .rst_n(rst_n), .par_i(tx_byte),
        .load_o(tx_load), .bit_o(tx_bit), .primed_o(tx_primed)
    );

    // Serial-I/O loopback replaces the external stream before recovery timing.
    always_comb begin
        rec_bit = lb_hsio ? tx_bit    : rx_ser_in;
        rec_en  = lb_hsio ? tx_primed : rx_bit_vld;
    end

    sdl_rx_deserializer #(.W(BYTE_W)) u_rx_rec (
        .clk(clk), .rst_n(rst_n), .bit_i(rec_bit), .en_i(rec_en),
        .word_o(rec_word), .vld_o(rec_vld)
    );

    sdl_rx_deserializer #(.W(BYTE_W)) u_rx_eq (
        .clk(clk), .rst_n(rst_n), .bit_i(tx_bit), .en_i(tx_primed),
        .word_o(eq_word), .vld_o(eq_vld)
    );

    sdl_fac_reserializer #(.W(BYTE_W)) u_fac (
        .clk(clk), .rst_n(rst_n), .word_i(rec_word), .en_i(rec_en),
        .bit_o(fac_bit)
    );

    // Equipment loopback owns the parallel output, facility owns the serial one.
    always_comb begin
        rx_byte     = lb_equip ? eq_word : rec_word;
        rx_byte_vld = lb_equip ? eq_vld  : rec_vld;
        ser_out     = lb_facility ? fac_bit : tx_bit;
    end
endmodule

// File: tb/tb_byte_serdes_lb.sv
module tb_byte_serdes_lb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       lb_equip = 1'b0, lb_hsio = 1'b0, lb_facility = 1'b0;
    logic [7:0] tx_byte = 8'h00;
    logic       tx_load, ser_out, rx_byte_vld;
    logic       rx_ser_in = 1'b0, rx_bit_vld = 1'b0;
    logic [7:0] rx_byte;

    int nchk = 0;
    int nerr = 0;
    logic [15:0] lfsr = 16'hACE1;
    int gen_k = 0;

    byte_serdes_lb dut (
        .clk(clk), .rst_n(rst_n), .lb_equip(lb_equip), .lb_hsio(lb_hsio),
        .lb_facility(lb_facility), .tx_byte(tx_byte), .tx_load(tx_load),
        .ser_out(ser_out), .rx_ser_in(rx_ser_in), .rx_bit_vld(rx_bit_vld),
        .rx_byte(rx_byte), .rx_byte_vld(rx_byte_vld)
    );

    always #4 clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s act=%0h exp=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [7:0] next_tx();
        gen_k++;
        if (gen_k % 7 == 0)  return 8'hFF;
        if (gen_k % 11 == 0) return 8'h00;
        return 8'((gen_k * 59 + 90) ^ (gen_k << 3));
    endfunction

    task automatic step_lfsr();
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    endtask

    // vmode: 0 = bit every cycle, 1 = pseudo-random strobe, 2 = every third cycle
    task automatic run_phase(input logic eq, input logic fa, input logic hs,
                             input int ncyc, input int vmode);
        logic [7:0] expq [0:255];
        logic       fhist [0:511];
        int wr = 0, rd = 0, ne = 0, nacc = 0, got = 0;
        logic [7:0] acc = 8'h00;
        logic [7:0] last_b = 8'h00;
        int idx = 0;
        logic started = 1'b0;
        string rreq, sreq;
        rreq = eq ? "R6" : (hs ? "R7" : (vmode != 0 ? "R4" : "R5"));
        sreq = fa ? (eq ? "R9" : "R8") : (eq ? "R6" : (hs ? "R7" : "R1"));
        @(negedge clk);
        rst_n = 1'b0; lb_equip = eq; lb_facility = fa; lb_hsio = hs;
        tx_byte = 8'h00; rx_ser_in = 1'b0; rx_bit_vld = 1'b0;
        repeat (3) @(negedge clk);
        // R10: outputs while reset is held
        chk("R10 rx_byte", 32'(rx_byte), 32'h0);
        chk("R10 rx_byte_vld", 32'(rx_byte_vld), 32'h0);
        chk("R10 ser_out", 32'(ser_out), 32'h0);
        chk("R10 tx_load", 32'(tx_load), 32'h1);
        rst_n = 1'b1;
        for (int cyc = 0; cyc < ncyc; cyc++) begin
            logic txb, txen, eb, een, rb, ren, fb, fen, sexp;
            if (cyc != 0) @(negedge clk);
            // R2: load strobe on every eighth cycle from release
            chk("R2 tx_load", 32'(tx_load), 32'(cyc % 8 == 0));
            txb  = started ? last_b[7 - idx] : 1'b0;
            txen = started;
            if (fa) sexp = (ne >= 9) ? fhist[ne - 9] : 1'b0;
            else    sexp = txb;
            chk({sreq, " ser_out"}, 32'(ser_out), 32'(sexp));
            if (rx_byte_vld) begin
                got++;
                if (rd < wr) begin
                    chk({rreq, " rx_byte"}, 32'(rx_byte), 32'(expq[rd]));
                    rd++;
                end else begin
                    chk({rreq, " spurious rx_byte_vld"}, 32'(1), 32'(0));
                end
            end
            // transmit model: advance bit index, take a new byte every 8 cycles
            if (started) idx++;
            if (cyc % 8 == 0) begin
                last_b = next_tx(); tx_byte = last_b; idx = 0; started = 1'b1;
            end
            // external receive drive, with junk data on idle cycles
            step_lfsr();
            eb = lfsr[0];
            case (vmode)
                0: een = 1'b1;
                1: een = lfsr[3] ^ lfsr[7];
                default: een = (cyc % 3 == 0);
            endcase
            rx_ser_in = eb; rx_bit_vld = een;
            // stream seen by the parallel receive output
            rb = (eq || hs) ? txb : eb; ren = (eq || hs) ? txen : een;
            if (ren) begin
                acc = {acc[6:0], rb}; nacc++;
                if (nacc == 8) begin expq[wr] = acc; wr++; nacc = 0; end
            end
            // stream seen by the facility path
            fb = hs ? txb : eb; fen = hs ? txen : een;
            if (fen) begin fhist[ne] = fb; ne++; end
        end
        // R3: each completed group produced exactly one strobe
        chk({rreq, " R3 byte count"}, 32'(got >= wr - 1 && got >= 1), 32'h1);
    endtask

    initial begin
        #(8 * 150000);
        nerr++;
        $display("FAIL watchdog expired act=running exp=done");
        $display("Result: errors=%0d of %0d checks", nerr, nchk + 1);
        $finish;
    end

    initial begin
        run_phase(1'b0, 1'b0, 1'b0, 240, 0); // R1 R2 R3 R5
        run_phase(1'b0, 1'b0, 1'b0, 240, 1); // R4
        run_phase(1'b0, 1'b0, 1'b0, 240, 2); // R4
        run_phase(1'b1, 1'b0, 1'b0, 240, 1); // R6
        run_phase(1'b0, 1'b0, 1'b1, 240, 0); // R7
        run_phase(1'b0, 1'b1, 1'b0, 240, 0); // R8
        run_phase(1'b0, 1'b1, 1'b0, 300, 1); // R8
        run_phase(1'b1, 1'b1, 1'b0, 300, 2); // R9
        run_phase(1'b0, 1'b1, 1'b1, 240, 0); // R7 with facility
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule